// File: doc/BRIEF.md
# Modulation Symbol Stream Decoder

The decoder watches a 6-bit word produced by a frequency-to-code converter. The word is sampled once per clock. Each sample is sorted into one of three classes:

- a separator symbol;
- one of six data symbols;
- no symbol.

Data symbols travel framed. A separator has to be seen and held before each data symbol. A data symbol is reported only after its code has stayed in one range for a minimum number of cycles. This keeps short glitches, ringing between ranges and repeated codes from ever showing up as a false symbol.

Each accepted data symbol appears as a one-cycle pulse on `sym_valid`, together with a 3-bit index on `sym_idx`. Two parameters set the minimum hold times, both counted in clock cycles. `N_SYM` applies to data symbols and `N_TOP` applies to the separator. The integrator picks both values from the sample clock, so that a data symbol is reported well inside its allowed latency and a short separator is still caught.

Top module: `symdec`

## Requirements
- R1: Codes 0x3E and 0x3F (inclusive) are classified as the separator. No other code is a separator.
- R2: Data codes map to symbol indices as follows: 0x33..0x35 gives 0, 0x30..0x32 gives 1, 0x2D..0x2F gives 2, 0x2B..0x2C gives 3, 0x29..0x2A gives 4, and 0x26..0x28 gives 5. All ranges are inclusive, and `sym_idx` carries that index when `sym_valid` is high.
- R3: A data symbol is reported once its classification has been the same for `N_SYM` consecutive sampled cycles. `sym_valid` is high in the cycle that follows the `N_SYM`-th rising edge of the run.
- R4: The separator is armed only after `N_TOP` consecutive separator samples. A shorter separator run arms nothing.
- R5: A data symbol that arrives while no separator is armed is never reported.
- R6: Each armed separator allows at most one reported data symbol. A data code that repeats without a new separator is ignored.
- R7: A code outside every listed range is "no symbol". It restarts the hold count but does not disarm a separator that is already armed.
- R8: Any change of classification or symbol index restarts the hold count. A data run shorter than `N_SYM` is never reported.
- R9: A synchronous active-high reset disarms the separator and holds `sym_valid` low.
- R10: `sym_valid` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | 6 | Converter output word, sampled on every rising edge |
| sym_valid | output | 1 | One-cycle pulse marking an accepted data symbol |
| sym_idx | output | 3 | Index of the accepted symbol (0..5), meaningful while `sym_valid` is high |

## Verification
Wrong internal state shows at the ports in one of three ways:

- A stale armed-separator flag makes a pulse appear for a data run that has no framing separator.
- A separator flag cleared when it should not be makes a correctly framed symbol go missing.
- A hold counter that is off by one moves the pulse one cycle early or late, measured from the start of the run.

Each of these faults becomes visible no later than the `N_SYM`-th cycle of the next data run. For that reason the bench compares the outputs on every cycle against its own model. It also sweeps all 64 codes, so that every range boundary is exercised.

// File: rtl/symdec_pkg.sv
package symdec_pkg;

  localparam int CODE_W = 6;
  localparam int NUM_DATA = 6;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_TOP  = 2'd1,
    K_DATA = 2'd2
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [2:0] idx;
  } sym_cls_t;

  localparam logic [CODE_W-1:0] TOP_LO = 6'h3E;
  localparam logic [CODE_W-1:0] TOP_HI = 6'h3F;

  localparam logic [CODE_W-1:0] DATA_LO [NUM_DATA] = '{6'h33, 6'h30, 6'h2D, 6'h2B, 6'h29, 6'h26};
  localparam logic [CODE_W-1:0] DATA_HI [NUM_DATA] = '{6'h35, 6'h32, 6'h2F, 6'h2C, 6'h2A, 6'h28};

  // Sort one code word into separator, data symbol with index, or nothing.
  function automatic sym_cls_t classify(input logic [CODE_W-1:0] code);
    sym_cls_t r;
    r.kind = K_NONE;
    r.idx  = 3'd0;
    if (code >= TOP_LO && code <= TOP_HI) begin
      r.kind = K_TOP;
    end else begin
      for (int i = NUM_DATA - 1; i >= 0; i--) begin
        if (code >= DATA_LO[i] && code <= DATA_HI[i]) begin
          r.kind = K_DATA;
          r.idx  = 3'(i);
        end
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/symdec_classify.sv
module symdec_classify
  import symdec_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output sym_cls_t          cls
);

  always_comb cls = classify(code);

endmodule

// File: rtl/symdec_runlen.sv
module symdec_runlen
  import symdec_pkg::*;
#(
  parameter int N_SYM = 6,
  parameter int N_TOP = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  sym_cls_t   cls,
  output logic       top_hit,
  output logic       data_hit,
  output logic [2:0] hit_idx
);

  localparam int NMAX = (N_SYM > N_TOP) ? N_SYM : N_TOP;
  localparam int CMAX = NMAX + 1;
  localparam int CW   = $clog2(CMAX + 1);

  sym_cls_t        prev_q;
  logic [CW-1:0]   run_q;
  logic [CW-1:0]   run_nxt;
  logic            same;

  always_comb begin
    same = (cls == prev_q);
    if (!same)                    run_nxt = CW'(1);
    else if (run_q == CW'(CMAX))  run_nxt = run_q;
    else                          run_nxt = run_q + CW'(1);
  end

  // The count saturates above both thresholds, so each crossing happens once per run.
  assign top_hit  = (cls.kind == K_TOP)  && (run_nxt == CW'(N_TOP));
  assign data_hit = (cls.kind == K_DATA) && (run_nxt == CW'(N_SYM));
  assign hit_idx  = cls.idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '{kind: K_NONE, idx: 3'd0};
      run_q  <= '0;
    end else begin
      prev_q <= cls;
      run_q  <= run_nxt;
    end
  end

endmodule

// File: rtl/symdec_framer.sv
module symdec_framer (
  input  logic       clk,
  input  logic       rst,
  input  logic       top_hit,
  input  logic       data_hit,
  input  logic [2:0] hit_idx,
  output logic       sep_armed,
  output logic       sym_valid,
  output logic [2:0] sym_idx
);

  logic emit;
  assign emit = data_hit && sep_armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      sep_armed <= 1'b0;
      sym_valid <= 1'b0;
      sym_idx   <= 3'd0;
    end else begin
      sym_valid <= emit;
      if (emit) sym_idx <= hit_idx;
      if (top_hit)   sep_armed <= 1'b1;
      else if (emit) sep_armed <= 1'b0;
    end
  end

endmodule

// File: rtl/symdec.sv
module symdec
  import symdec_pkg::*;
#(
  parameter int N_SYM = 6,
  parameter int N_TOP = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_in,
  output logic              sym_valid,
  output logic [2:0]        sym_idx
);

  sym_cls_t   cls;
  logic       top_hit;
  logic       data_hit;
  logic [2:0] hit_idx;
  logic       sep_armed;

  symdec_classify u_cls (
    .code (code_in),
    .cls  (cls)
  );

  symdec_runlen #(.N_SYM(N_SYM), .N_TOP(N_TOP)) u_run (
    .clk      (clk),
    .rst      (rst),
    .cls      (cls),
    .top_hit  (top_hit),
    .data_hit (data_hit),
    .hit_idx  (hit_idx)
  );

  symdec_framer u_frm (
    .clk       (clk),
    .rst       (rst),
    .top_hit   (top_hit),
    .data_hit  (data_hit),
    .hit_idx   (hit_idx),
    .sep_armed (sep_armed),
    .sym_valid (sym_valid),
    .sym_idx   (sym_idx)
  );

endmodule

// File: rtl/symdec_sva.sv
module symdec_sva
  import symdec_pkg::*;
#(
  parameter int N_SYM = 6,
  parameter int N_TOP = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] code_in,
  input logic              sym_valid,
  input logic [2:0]        sym_idx,
  input logic              top_hit,
  input logic              data_hit,
  input logic              sep_armed
);

  // Independent run-length tracker on the raw code classification.
  sym_cls_t    c_cls;
  sym_cls_t    c_prev;
  logic [15:0] c_run;

  always_comb c_cls = classify(code_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      c_prev <= '{kind: K_NONE, idx: 3'd0};
      c_run  <= '0;
    end else begin
      c_prev <= c_cls;
      if (c_cls != c_prev)        c_run <= 16'd1;
      else if (c_run != 16'hFFFF) c_run <= c_run + 16'd1;
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    sym_valid |-> (sym_idx < 3'd6)); // R2

  AST_IDX_MATCHES_CODE: assert property (@(posedge clk) disable iff (rst)
    sym_valid |-> (c_prev.kind == K_DATA && c_prev.idx == sym_idx)); // R2

  AST_HOLD_EXACT: assert property (@(posedge clk) disable iff (rst)
    sym_valid |-> (c_run == 16'(N_SYM))); // R3

  AST_TOP_ARMS: assert property (@(posedge clk) disable iff (rst)
    top_hit |=> sep_armed); // R4

  AST_ARM_CONSUMED: assert property (@(posedge clk) disable iff (rst)
    (data_hit && sep_armed && !top_hit) |=> (sym_valid && !sep_armed)); // R6

  AST_UNARMED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (data_hit && !sep_armed) |=> !sym_valid); // R5

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    sym_valid |=> !sym_valid); // R10

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!sym_valid && !sep_armed)); // R9

endmodule

bind symdec symdec_sva #(.N_SYM(N_SYM), .N_TOP(N_TOP)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .code_in   (code_in),
  .sym_valid (sym_valid),
  .sym_idx   (sym_idx),
  .top_hit   (top_hit),
  .data_hit  (data_hit),
  .sep_armed (sep_armed)
);

// File: tb/symdec_test.sv
module symdec_test;

  localparam int NS = 6;
  localparam int NT = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] code_in = 6'h00;
  logic       sym_valid;
  logic [2:0] sym_idx;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Bench model state.
  int m_key  = -1;
  int m_run  = 0;
  bit m_sep  = 0;
  bit e_v    = 0;
  int e_idx  = 0;

  always #4 clk = ~clk;

  symdec #(.N_SYM(NS), .N_TOP(NT)) uut (
    .clk(clk), .rst(rst), .code_in(code_in),
    .sym_valid(sym_valid), .sym_idx(sym_idx)
  );

  // -1 no symbol, 6 separator, 0..5 data index.
  function automatic int key_of(input logic [5:0] c);
    int v = int'(c);
    if (v >= 62) return 6;
    if (v >= 51 && v <= 53) return 0;
    if (v >= 48 && v <= 50) return 1;
    if (v >= 45 && v <= 47) return 2;
    if (v >= 43 && v <= 44) return 3;
    if (v >= 41 && v <= 42) return 4;
    if (v >= 38 && v <= 40) return 5;
    return -1;
  endfunction

  task automatic check(input string tag);
    n_checks++;
    if (sym_valid !== e_v || (e_v && int'(sym_idx) != e_idx)) begin
      n_fail++;
      $display("FAIL %s: valid=%0b idx=%0d expected valid=%0b idx=%0d",
               tag, sym_valid, sym_idx, e_v, e_idx);
    end
  endtask

  task automatic step(input logic [5:0] c, input logic r, input string tag);
    int k;
    @(negedge clk);
    code_in = c;
    rst = r;
    k = key_of(c);
    e_v = 0;
    if (r) begin
      m_key = -1; m_run = 0; m_sep = 0;
    end else begin
      if (k == m_key) m_run++; else m_run = 1;
      m_key = k;
      if (k == 6 && m_run == NT) m_sep = 1;
      else if (k >= 0 && k < 6 && m_run == NS && m_sep) begin
        e_v = 1; e_idx = k; m_sep = 0;
      end
    end
    @(posedge clk);
    #1;
    check(tag);
  endtask

  task automatic hold(input logic [5:0] c, input int n, input string tag);
    for (int i = 0; i < n; i++) step(c, 1'b0, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    step(6'h00, 1'b1, "R9 reset");
    step(6'h3E, 1'b1, "R9 reset with separator code");
    // Basic framed symbol
    hold(6'h3F, NT, "R1 R4 separator");
    hold(6'h34, NS + 2, "R2 R3 symbol A");
    // A, B, A framed sequence
    hold(6'h3E, NT, "R4 sep");  hold(6'h31, NS, "R3 B");
    hold(6'h3E, NT, "R4 sep");  hold(6'h33, NS, "R3 A");
    // Short separator does not arm
    hold(6'h00, 2, "R7 gap");
    hold(6'h3E, NT - 1, "R4 short sep");
    hold(6'h2E, NS + 1, "R4 R5 unarmed C");
    // Data without separator
    hold(6'h27, NS + 3, "R5 no sep");
    // Once per separator: A, none, A
    hold(6'h3F, NT, "R6 sep");
    hold(6'h35, NS, "R6 first A");
    hold(6'h10, 2, "R7 gap");
    hold(6'h35, NS, "R6 repeat A");
    // None keeps armed separator
    hold(6'h3F, NT, "R7 sep");
    hold(6'h3D, 3, "R7 none");
    hold(6'h2B, NS, "R7 D after none");
    // Short data then a change restarts the count
    hold(6'h3E, NT, "R8 sep");
    hold(6'h29, NS - 1, "R8 short E");
    hold(6'h26, NS - 1, "R8 short F");
    hold(6'h26, 2, "R8 F completes");
    // Change inside one symbol range does not restart
    hold(6'h3E, NT, "R8 sep");
    hold(6'h30, 2, "R2 B lo");
    hold(6'h32, NS, "R2 B hi");
    // Reset while armed
    hold(6'h3E, NT, "R9 sep");
    step(6'h3E, 1'b1, "R9 reset armed");
    hold(6'h2A, NS + 1, "R9 disarmed");
    // Sweep all codes
    for (int c = 0; c < 64; c++) begin
      hold(6'h3F, NT, "R1 sweep sep");
      hold(6'(c), NS + 1, "R1 R2 sweep code");
      hold(6'h00, 1, "R7 sweep gap");
    end
    // Random segments
    for (int s = 0; s < 600; s++) begin
      int sel = $urandom_range(0, 99);
      int dur = $urandom_range(1, NS + 3);
      logic [5:0] c;
      if (sel < 30)      c = 6'($urandom_range(62, 63));
      else if (sel < 80) c = 6'($urandom_range(38, 53));
      else               c = 6'($urandom_range(0, 63));
      if ($urandom_range(0, 99) < 2) step(c, 1'b1, "R9 random reset");
      else hold(c, dur, "R3 R6 R8 R10 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial void'($urandom(32'd1234));

endmodule